// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked host to an external static RAM that has no clock. The RAM holds 128K words of 16 bits, split into two byte lanes. The host hands over one request at a time: an address, a read or write flag, write data and a lane mask. The controller turns each request into a sequence of registered active-low strobes that meets the part's minimum pulse, setup and bus-turnaround times. Each phase length is a whole number of clock cycles, set by parameters.

For a read, the controller asserts chip select and output enable together with the selected lane strobes. It captures the bus at the last clock of the read phase and returns the word with a one-cycle valid pulse. For a write, it drives the data bus and pulses write enable low. It then holds address, lanes and data for one more clock before it lets go. After every read it inserts a gap before the bus is handed back, so that the controller's drivers never overlap with the RAM's outputs.

The RAM data bus is split into an output word, a shared drive-enable and an input word. The pad ring builds the tri-state buffer from these.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, the controller is in this state: ready high; chip select, write enable, output enable and both lane strobes high; bus drive-enable low; read-valid low.
- R2: A read request accepted at clock edge k sets the following on that edge: chip select low, output enable low, write enable high, address equal to the request, and lane strobe n low exactly when mask bit n is 1. Bit 0 is the lower lane (data bits 7:0) and bit 1 is the upper lane (bits 15:8). These strobes stay active for RD_CYC cycles.
- R3: Read data is captured on edge k+RD_CYC. Read-valid is high for exactly the one cycle that follows. Data bits of a lane whose mask bit is 0 read as zero.
- R4: A write request accepted at edge k sets the following: chip select low, output enable high, and write enable low for exactly WR_CYC cycles. Only the lanes with mask bit 1 are stored, and a lane with mask bit 0 keeps its old contents.
- R5: During a write, the controller drives the bus with the request data. Address, lane strobes and bus data do not change while write enable is low. They are still the same, with the drive-enable still high, in the cycle after write enable returns high.
- R6: The bus drive-enable is never high while output enable is low. It is never high in the cycle directly after a cycle with output enable low.
- R7: Ready drops on the edge that accepts a request. It returns on edge k+RD_CYC+TURN_CYC after a read and on edge k+WR_CYC+1 after a write.
- R8: A request presented while ready is low is ignored: it produces no strobe and no change to memory.
- R9: Whenever chip select is high, both lane strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, taken when ready_o is high |
| ready_o | output | 1 | Controller can accept a request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rvalid_o | output | 1 | One-cycle read data valid |
| rdata_o | output | 16 | Read data |
| mem_addr_o | output | 17 | RAM address |
| mem_ce_no | output | 1 | RAM chip select, active low |
| mem_we_no | output | 1 | RAM write enable, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_be_no | output | 2 | RAM lane strobes, active low, bit 0 lower |
| mem_dq_o | output | 16 | Data driven toward the RAM |
| mem_dq_oe_o | output | 1 | Drive-enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned from the RAM |

## Verification
Each host operation is timed from its accept edge k:
- Strobes change on edge k.
- Read-valid and read data appear on edge k+RD_CYC.
- Write enable rises on edge k+WR_CYC.
- Ready comes back on edge k+RD_CYC+TURN_CYC after a read, or on edge k+WR_CYC+1 after a write.

The bench samples on the falling edge after each of these edges, counting cycles from k. Its RAM model returns valid data only after output enable has been low for the access-time clocks plus one, and returns filler bytes otherwise. A read phase that is too short is therefore caught as a data mismatch. The model also counts write-pulse length and checks hold and turnaround each cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_WHOLD
  } ctrl_state_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lane_q <= '0;
      else if (capture_i) lane_q <= lane_en_i[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
    end

    assign rdata_o[l*LANE_W +: LANE_W] = lane_q;

    // R3: a masked-off lane reads back as zero
    a_r3_masked_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      capture_i && !lane_en_i[l] |=> rdata_o[l*LANE_W +: LANE_W] == '0);
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int LANE_W   = 8,
  parameter int RD_CYC   = 3,
  parameter int WR_CYC   = 2,
  parameter int TURN_CYC = 1,
  localparam int LANES   = DATA_W / LANE_W,
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC)
                                            : ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC),
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [LANES-1:0]  mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  ctrl_state_e      state_q;
  logic [LANES-1:0] lane_en_q;
  logic             phase_done, tmr_load, capture;
  logic [CNT_W-1:0] tmr_val;

  wire accept = (state_q == ST_IDLE) && req_i;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = we_i ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
    end else if (state_q == ST_READ && phase_done) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(TURN_CYC - 1);
    end
  end

  assign capture = (state_q == ST_READ) && phase_done;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (phase_done)
  );

  sram_lane_io #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .lane_en_i (lane_en_q),
    .dq_i      (mem_dq_i),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ready_o     <= 1'b1;
      rvalid_o    <= 1'b0;
      lane_en_q   <= '0;
      mem_addr_o  <= '0;
      mem_ce_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_be_no   <= '1;
      mem_dq_o    <= '0;
      mem_dq_oe_o <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          ready_o    <= 1'b0;
          lane_en_q  <= be_i;
          mem_addr_o <= addr_i;
          mem_be_no  <= ~be_i;
          mem_ce_no  <= 1'b0;
          if (we_i) begin
            mem_we_no   <= 1'b0;
            mem_dq_o    <= wdata_i;
            mem_dq_oe_o <= 1'b1;
            state_q     <= ST_WRITE;
          end else begin
            mem_oe_no <= 1'b0;
            state_q   <= ST_READ;
          end
        end
        ST_READ: if (phase_done) begin
          mem_ce_no <= 1'b1;
          mem_oe_no <= 1'b1;
          mem_be_no <= '1;
          rvalid_o  <= 1'b1;
          state_q   <= ST_TURN;
        end
        ST_TURN: if (phase_done) begin
          ready_o <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_WRITE: if (phase_done) begin
          mem_we_no <= 1'b1;
          state_q   <= ST_WHOLD;
        end
        ST_WHOLD: begin
          mem_ce_no   <= 1'b1;
          mem_be_no   <= '1;
          mem_dq_oe_o <= 1'b0;
          ready_o     <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_read_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_ce_no && mem_we_no);
  a_r3_single_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
  a_r4_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no && !mem_ce_no);
  a_r5_stable_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no && $past(!mem_we_no) |-> $stable(mem_addr_o) && $stable(mem_dq_o) && $stable(mem_be_no));
  a_r5_hold_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> $stable(mem_addr_o) && $stable(mem_dq_o) && $stable(mem_be_no) && mem_dq_oe_o);
  a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
  a_r6_turn_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |=> !mem_dq_oe_o);
  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o |=> !ready_o);
  a_r9_deselect_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> &mem_be_no);
endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int AW = 17, DW = 16;
  localparam int RD = 3, WR = 2, TURN = 1;
  localparam int T_AA_CLK = 2;   // 7 ns access at 5 ns clock

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] be = '0;
  logic ready, rvalid, ce_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic [AW-1:0] m_addr;
  logic [1:0] m_be_n;

  int checks = 0, errors = 0;
  always #2.5 clk = ~clk;

  sram_async_ctrl #(.RD_CYC(RD), .WR_CYC(WR), .TURN_CYC(TURN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_be_no(m_be_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i));

  function automatic void chk(bit ok, string req_tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endfunction

  // RAM model: 256 words aliased on the low address byte
  logic [DW-1:0] mdata [0:255];
  logic [DW-1:0] shadow [0:255];
  int rd_cnt = 0, wl_cnt = 0, nwrites = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] wl_addr;
  logic [DW-1:0] wl_dq;
  logic [1:0] wl_be;

  initial for (int i = 0; i < 256; i++) begin
    mdata[i]  = {i[7:0], ~i[7:0]};
    shadow[i] = DW'((i << 8) | (i ^ 8'hFF));
  end

  always_comb begin
    for (int l = 0; l < 2; l++)
      dq_i[l*8 +: 8] = (!ce_n && !oe_n && we_n && !m_be_n[l] && rd_cnt >= T_AA_CLK + 1)
                       ? mdata[m_addr[7:0]][l*8 +: 8] : 8'h5A;
  end

  always @(negedge clk) if (rst_n) begin
    if (!ce_n && !oe_n && we_n) rd_cnt = rd_cnt + 1; else rd_cnt = 0;
    if (!we_n) begin
      if (prev_we) begin
        wl_addr = m_addr; wl_dq = dq_o; wl_be = m_be_n; wl_cnt = 1;
      end else begin
        wl_cnt++;
        chk(m_addr == wl_addr && dq_o == wl_dq && m_be_n == wl_be, "R5", "pulse stability", dq_o, wl_dq);
      end
      chk(!ce_n && oe_n, "R4", "ce/oe during write", {ce_n, oe_n}, 2'b01);
    end else if (!prev_we) begin
      chk(m_addr == wl_addr && dq_o == wl_dq && m_be_n == wl_be && dq_oe, "R5", "hold after rise", dq_o, wl_dq);
      chk(wl_cnt == WR, "R4", "write pulse length", wl_cnt, WR);
      if (!ce_n) begin
        for (int l = 0; l < 2; l++)
          if (!m_be_n[l]) mdata[m_addr[7:0]][l*8 +: 8] = dq_o[l*8 +: 8];
        nwrites++;
      end
    end
    if (dq_oe) chk(oe_n && prev_oe, "R6", "drive vs output enable", {prev_oe, oe_n}, 2'b11);
    if (ce_n) chk(m_be_n == 2'b11, "R9", "lanes when deselected", m_be_n, 2'b11);
    prev_we = we_n;
    prev_oe = oe_n;
  end

  function automatic logic [AW-1:0] addr_of(int i);
    logic [15:0] lo = 16'(i * 16'h1111);
    return {1'(i & 1), lo};
  endfunction

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] m);
    @(negedge clk);
    chk(ready, "R7", "ready before write", ready, 1);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = m;
    @(negedge clk);
    req = 1'b0;
    chk(!we_n && oe_n && !ce_n && dq_oe, "R4", "write strobes", {we_n, oe_n, ce_n, dq_oe}, 4'b0101);
    chk(m_be_n == ~m && m_addr == a, "R4", "write lanes/addr", m_be_n, ~m);
    chk(dq_o == d, "R5", "bus data", dq_o, d);
    for (int l = 0; l < 2; l++) if (m[l]) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
    for (int j = 1; j <= WR + 1; j++) begin
      @(negedge clk);
      chk(ready == (j == WR + 1), "R7", "ready after write", ready, j == WR + 1);
    end
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [1:0] m, bit intrude);
    logic [DW-1:0] exp = shadow[a[7:0]] & {{8{m[1]}}, {8{m[0]}}};
    @(negedge clk);
    chk(ready, "R7", "ready before read", ready, 1);
    req = 1'b1; we = 1'b0; addr = a; be = m;
    @(negedge clk);
    req = 1'b0;
    chk(!ce_n && !oe_n && we_n && !dq_oe, "R2", "read strobes", {ce_n, oe_n, we_n, dq_oe}, 4'b0010);
    chk(m_be_n == ~m && m_addr == a, "R2", "read lanes/addr", m_be_n, ~m);
    for (int j = 1; j <= RD + TURN; j++) begin
      if (intrude && j == 1) begin
        req = 1'b1; we = 1'b1; addr = a ^ 17'h00055; wdata = 16'hBEEF; be = 2'b11;
      end
      if (intrude && j == 2) req = 1'b0;
      @(negedge clk);
      if (j < RD) chk(!oe_n, "R2", "read strobe length", oe_n, 0);
      chk(rvalid == (j == RD), "R3", "valid pulse", rvalid, j == RD);
      if (j == RD) chk(rdata == exp, "R3", "read data", rdata, exp);
      chk(ready == (j == RD + TURN), "R7", "ready after read", ready, j == RD + TURN);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nw;
    repeat (3) @(negedge clk);
    chk(ready && ce_n && we_n && oe_n && m_be_n == 2'b11 && !dq_oe && !rvalid,
        "R1", "reset state", {ready, ce_n, we_n, oe_n, m_be_n, dq_oe, rvalid}, 8'b1111_1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && ce_n && !dq_oe, "R1", "state after release", {ready, ce_n, dq_oe}, 3'b110);

    for (int i = 0; i < 16; i++) do_read(addr_of(i), 2'b11, 1'b0);
    for (int i = 0; i < 16; i++) do_write(addr_of(i), 16'h0F0F ^ 16'(i * 16'h1357), 2'(i % 4));
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 4; m++) do_read(addr_of(i), 2'(m), 1'b0);

    // back-to-back read/write/read exercises turnaround (R6)
    do_read(addr_of(3), 2'b11, 1'b0);
    do_write(addr_of(3), 16'hA5C3, 2'b10);
    do_read(addr_of(3), 2'b11, 1'b0);

    // R8: request during a busy read is dropped
    nw = nwrites;
    do_read(addr_of(5), 2'b11, 1'b1);
    repeat (4) @(negedge clk);
    chk(nwrites == nw, "R8", "no write from ignored request", nwrites, nw);
    do_read(addr_of(5) ^ 17'h00055, 2'b11, 1'b0);

    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule